// File: doc/BRIEF.md
# Reset Sequencer with Boot Vector Capture

This block sits at the root of a chip's reset tree. While the cold reset input is held low, it samples an 11-bit boot configuration word on every clock. The word comes either from a set of address pins or, when the internal-vector select is high, from a build-time parameter. When cold reset is released through a synchronizer, the last sampled word is frozen. It then stays visible on a register output until the next cold reset.

The block stretches its system reset output. The output stays low for at least a parameterized minimum number of master clocks, 4000 by default. When the internal vector is in use, the output also waits for a PLL settling interval. That interval is timed by a counter of parameterized width, 18 bits by default, running on the master clock. Both intervals must finish before the output rises.

From the frozen word, the block decodes its fields into the settings used by the rest of the chip:

- the PLL multiplier, or bypass
- the external clock divider
- byte order
- the PCI operating mode, the initial PCI enable value, and the arbiter style

Any reserved code is reported on a per-field flag. A reserved multiplier or divider code falls back to a safe setting.

Top module: `rstseq_top`

## Requirements
- R1: While `cold_rst_n` is low and `int_vec_sel` is low, `boot_pins` is sampled. After release, `boot_vec` holds the value the pins had at release, and later changes on `boot_pins` or `int_vec_sel` have no effect on it.
- R2: When `int_vec_sel` is high during cold reset, `boot_vec` takes the parameter `INT_VEC`, and `boot_pins` is ignored.
- R3: `sys_rst_n` is low while `cold_rst_n` is low. After release, it stays low for at least `MIN_RST_CYCLES` clocks and rises no later than `MIN_RST_CYCLES`+6 clocks when the PLL wait does not apply.
- R4: With the internal vector, `sys_rst_n` also waits for 2^`PLL_CNT_W` clocks of the settling counter. It rises within 6 clocks after the later of the two intervals ends.
- R5: Once high, `sys_rst_n` stays high until the next cold reset.
- R6: The multiplier code is in bits 3:0. Codes 1, 2, 4, 6, 7 and 8 give `mult_factor` 3, 4, 5, 6, 8 and 10 with `pll_bypass`=0. Code 0 and every reserved code give `pll_bypass`=1 and `mult_factor`=1.
- R7: The divider code is in bits 5:4. Codes 0, 1 and 2 give `ext_div_factor` 1, 2 and 4. Reserved code 3 gives 1.
- R8: `big_endian` equals bit 6 (1 = big endian, 0 = little endian).
- R9: `pci_mode` equals bits 10:8. `pci_en_init` is 1 only for modes 1 and 2.
- R10: `arb_internal` is 1 for modes 4 and 5. `arb_round_robin` is 1 only for mode 5.
- R11: `rsv_flags` has one bit per field: bit 0 for a reserved multiplier (3, 5, 9..15), bit 1 for divider code 3, bit 2 for reset-mode bit 7 set, and bit 3 for PCI modes 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| cold_rst_n | input | 1 | Cold reset, active low, asynchronous assert |
| boot_pins | input | 11 | Boot word from the address pins |
| int_vec_sel | input | 1 | Use the internal vector instead of the pins |
| sys_rst_n | output | 1 | Stretched system reset, active low |
| boot_vec | output | 11 | Captured boot word |
| pll_bypass | output | 1 | PLL bypassed |
| mult_factor | output | 4 | PLL multiplication factor |
| ext_div_factor | output | 3 | External clock divide factor |
| big_endian | output | 1 | Byte order select |
| pci_mode | output | 3 | PCI operating mode code |
| pci_en_init | output | 1 | Initial PCI enable value |
| arb_internal | output | 1 | Internal PCI arbiter in use |
| arb_round_robin | output | 1 | Arbiter uses round robin |
| rsv_flags | output | 4 | Reserved-code flags per field |

## Verification
Boot words are driven that walk every valid multiplier code and every PCI mode. This separates each decode arm from its neighbours and from the bypass fallback. One word sets every reserved code at once, and another uses reserved multiplier 15 with PCI mode 7. Together they show that the fallback and each flag bit act independently. Cases using the pins and cases using the internal vector with garbage on the pins show whether capture obeys the select. Their release times, one set by the minimum hold and one set by the longer PLL counter, show whether the output waits for the later of the two intervals.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
   localparam int unsigned BOOT_W = 11;

   typedef struct packed {
      logic [2:0] pci_mode;
      logic       rst_mode;
      logic       endian;
      logic [1:0] div_code;
      logic [3:0] mult_code;
   } boot_cfg_t;

   localparam logic [2:0] PCI_SAT_NRDY  = 3'd1;
   localparam logic [2:0] PCI_SAT_HOLD  = 3'd2;
   localparam logic [2:0] PCI_HOST_FIX  = 3'd4;
   localparam logic [2:0] PCI_HOST_RR   = 3'd5;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_s_n
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rstseq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign rst_s_n = chain[STAGES-1];
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
   parameter int unsigned LIMIT = 4000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic done
);
   localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

   generate
      if (LIMIT <= 1) begin : g_short
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  done <= 1'b0;
            else if (en) done <= 1'b1;
         end
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt  <= '0;
               done <= 1'b0;
            end else if (en && !done) begin
               if (cnt == CW'(LIMIT - 1)) done <= 1'b1;
               else                       cnt  <= cnt + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/rstseq_decode.sv
module rstseq_decode
   import rstseq_pkg::*;
(
   input  boot_cfg_t  cfg,
   output logic       pll_bypass,
   output logic [3:0] mult_factor,
   output logic [2:0] ext_div_factor,
   output logic       big_endian,
   output logic [2:0] pci_mode,
   output logic       pci_en_init,
   output logic       arb_internal,
   output logic       arb_round_robin,
   output logic [3:0] rsv_flags
);
   always_comb begin
      pll_bypass     = 1'b1;
      mult_factor    = 4'd1;
      ext_div_factor = 3'd1;
      rsv_flags      = 4'b0000;

      case (cfg.mult_code)
         4'h0: ;
         4'h1: begin pll_bypass = 1'b0; mult_factor = 4'd3;  end
         4'h2: begin pll_bypass = 1'b0; mult_factor = 4'd4;  end
         4'h4: begin pll_bypass = 1'b0; mult_factor = 4'd5;  end
         4'h6: begin pll_bypass = 1'b0; mult_factor = 4'd6;  end
         4'h7: begin pll_bypass = 1'b0; mult_factor = 4'd8;  end
         4'h8: begin pll_bypass = 1'b0; mult_factor = 4'd10; end
         default: rsv_flags[0] = 1'b1;
      endcase

      case (cfg.div_code)
         2'd0:    ext_div_factor = 3'd1;
         2'd1:    ext_div_factor = 3'd2;
         2'd2:    ext_div_factor = 3'd4;
         default: rsv_flags[1]   = 1'b1;
      endcase

      rsv_flags[2] = cfg.rst_mode;
      rsv_flags[3] = (cfg.pci_mode >= 3'd6);
   end

   assign big_endian      = cfg.endian;
   assign pci_mode        = cfg.pci_mode;
   assign pci_en_init     = (cfg.pci_mode == PCI_SAT_NRDY) || (cfg.pci_mode == PCI_SAT_HOLD);
   assign arb_internal    = (cfg.pci_mode == PCI_HOST_FIX) || (cfg.pci_mode == PCI_HOST_RR);
   assign arb_round_robin = (cfg.pci_mode == PCI_HOST_RR);
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
   import rstseq_pkg::*;
#(
   parameter int unsigned MIN_RST_CYCLES = 4000,
   parameter int unsigned PLL_CNT_W      = 18,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter logic [10:0] INT_VEC        = 11'h557
) (
   input  logic        clk,
   input  logic        cold_rst_n,
   input  logic [10:0] boot_pins,
   input  logic        int_vec_sel,
   output logic        sys_rst_n,
   output logic [10:0] boot_vec,
   output logic        pll_bypass,
   output logic [3:0]  mult_factor,
   output logic [2:0]  ext_div_factor,
   output logic        big_endian,
   output logic [2:0]  pci_mode,
   output logic        pci_en_init,
   output logic        arb_internal,
   output logic        arb_round_robin,
   output logic [3:0]  rsv_flags
);
   localparam int unsigned PLL_LIMIT = 1 << PLL_CNT_W;

   generate
      if (MIN_RST_CYCLES < 1) begin : g_bad_min
         $error("rstseq_top: MIN_RST_CYCLES must be at least 1");
      end
      if (PLL_CNT_W < 1 || PLL_CNT_W > 30) begin : g_bad_pll
         $error("rstseq_top: PLL_CNT_W out of range 1..30");
      end
   endgenerate

   logic        rst_s_n;
   logic [10:0] vec_q;
   logic        sel_q;
   logic        min_done;
   logic        pll_done;
   logic        sys_q;

   rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .arst_n  (cold_rst_n),
      .rst_s_n (rst_s_n)
   );

   // Capture follows the source for as long as reset is active, then freezes.
   always_ff @(posedge clk) begin
      if (!rst_s_n) begin
         vec_q <= int_vec_sel ? INT_VEC : boot_pins;
         sel_q <= int_vec_sel;
      end
   end

   rstseq_timer #(.LIMIT(MIN_RST_CYCLES)) u_min_tmr (
      .clk   (clk),
      .rst_n (rst_s_n),
      .en    (1'b1),
      .done  (min_done)
   );

   rstseq_timer #(.LIMIT(PLL_LIMIT)) u_pll_tmr (
      .clk   (clk),
      .rst_n (rst_s_n),
      .en    (sel_q),
      .done  (pll_done)
   );

   always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n) sys_q <= 1'b0;
      else          sys_q <= min_done & (pll_done | ~sel_q);
   end

   assign sys_rst_n = sys_q;
   assign boot_vec  = vec_q;

   rstseq_decode u_dec (
      .cfg             (boot_cfg_t'(vec_q)),
      .pll_bypass      (pll_bypass),
      .mult_factor     (mult_factor),
      .ext_div_factor  (ext_div_factor),
      .big_endian      (big_endian),
      .pci_mode        (pci_mode),
      .pci_en_init     (pci_en_init),
      .arb_internal    (arb_internal),
      .arb_round_robin (arb_round_robin),
      .rsv_flags       (rsv_flags)
   );
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
   parameter int unsigned MIN = 4000
) (
   input logic        clk,
   input logic        cold_rst_n,
   input logic        sys_rst_n,
   input logic [10:0] boot_vec,
   input logic        pll_bypass,
   input logic [2:0]  ext_div_factor,
   input logic        pci_en_init,
   input logic        arb_internal,
   input logic        arb_round_robin,
   input logic [3:0]  rsv_flags
);
   logic [31:0] cyc;

   always_ff @(posedge clk or negedge cold_rst_n) begin
      if (!cold_rst_n)       cyc <= '0;
      else if (cyc != '1)    cyc <= cyc + 1'b1;
   end

   a_r3_min_hold: assert property (@(posedge clk) disable iff (!cold_rst_n)
      $rose(sys_rst_n) |-> (cyc >= MIN));

   a_r5_stays_high: assert property (@(posedge clk) disable iff (!cold_rst_n)
      $past(sys_rst_n) |-> sys_rst_n);

   a_r1_vec_frozen: assert property (@(posedge clk) disable iff (!cold_rst_n)
      sys_rst_n |-> $stable(boot_vec));

   a_r11_rsv_bypass: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (sys_rst_n && rsv_flags[0]) |-> pll_bypass);

   a_r7_div_single: assert property (@(posedge clk) disable iff (!cold_rst_n)
      sys_rst_n |-> ($countones(ext_div_factor) == 1));

   a_r10_rr_internal: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (sys_rst_n && arb_round_robin) |-> arb_internal);

   a_r9_en_not_host: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (sys_rst_n && pci_en_init) |-> !arb_internal);
endmodule

bind rstseq_top rstseq_chk #(.MIN(MIN_RST_CYCLES)) u_chk (
   .clk             (clk),
   .cold_rst_n      (cold_rst_n),
   .sys_rst_n       (sys_rst_n),
   .boot_vec        (boot_vec),
   .pll_bypass      (pll_bypass),
   .ext_div_factor  (ext_div_factor),
   .pci_en_init     (pci_en_init),
   .arb_internal    (arb_internal),
   .arb_round_robin (arb_round_robin),
   .rsv_flags       (rsv_flags)
);

// File: tb/rstseq_top_test.sv
`timescale 1ns/1ps
module rstseq_top_test;
   localparam int unsigned T_MIN = 300;
   localparam int unsigned T_PW  = 10;
   localparam logic [10:0] T_IV  = 11'h557;

   typedef struct {
      logic [10:0] vec;
      logic        byp;
      logic [3:0]  mf;
      logic [2:0]  df;
      logic        be;
      logic [2:0]  pm;
      logic        pe;
      logic        ai;
      logic        rr;
      logic [3:0]  rf;
      int          lo;
      int          hi;
   } exp_t;

   logic        clk = 1'b0;
   logic        cold_rst_n = 1'b0;
   logic [10:0] boot_pins = '0;
   logic        int_vec_sel = 1'b0;
   logic        sys_rst_n;
   logic [10:0] boot_vec;
   logic        pll_bypass;
   logic [3:0]  mult_factor;
   logic [2:0]  ext_div_factor;
   logic        big_endian;
   logic [2:0]  pci_mode;
   logic        pci_en_init;
   logic        arb_internal;
   logic        arb_round_robin;
   logic [3:0]  rsv_flags;

   int   total = 0;
   int   bad   = 0;
   exp_t sb[$];
   int   relcnt = 0;
   bit   seen = 0;
   bit   got  = 0;

   always #2.5 clk = ~clk;

   rstseq_top #(.MIN_RST_CYCLES(T_MIN), .PLL_CNT_W(T_PW), .INT_VEC(T_IV)) uut (
      .clk(clk), .cold_rst_n(cold_rst_n), .boot_pins(boot_pins), .int_vec_sel(int_vec_sel),
      .sys_rst_n(sys_rst_n), .boot_vec(boot_vec), .pll_bypass(pll_bypass),
      .mult_factor(mult_factor), .ext_div_factor(ext_div_factor), .big_endian(big_endian),
      .pci_mode(pci_mode), .pci_en_init(pci_en_init), .arb_internal(arb_internal),
      .arb_round_robin(arb_round_robin), .rsv_flags(rsv_flags)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_rng(input string req, input int act, input int lo, input int hi);
      total++;
      if (act < lo || act > hi) begin
         bad++;
         $display("FAIL %s release cycle: actual=%0d expected=%0d..%0d", req, act, lo, hi);
      end
   endtask

   function automatic exp_t model(input logic [10:0] pins, input bit isel);
      exp_t e;
      e.vec = isel ? T_IV : pins;
      e.byp = 1'b0; e.rf = 4'b0;
      case (e.vec[3:0])
         4'h1: e.mf = 3;  4'h2: e.mf = 4;  4'h4: e.mf = 5;
         4'h6: e.mf = 6;  4'h7: e.mf = 8;  4'h8: e.mf = 10;
         4'h0: begin e.mf = 1; e.byp = 1'b1; end
         default: begin e.mf = 1; e.byp = 1'b1; e.rf[0] = 1'b1; end
      endcase
      case (e.vec[5:4])
         2'd0: e.df = 1; 2'd1: e.df = 2; 2'd2: e.df = 4;
         default: begin e.df = 1; e.rf[1] = 1'b1; end
      endcase
      e.be = e.vec[6];
      e.rf[2] = e.vec[7];
      e.pm = e.vec[10:8];
      e.pe = (e.pm == 3'd1 || e.pm == 3'd2);
      e.ai = (e.pm == 3'd4 || e.pm == 3'd5);
      e.rr = (e.pm == 3'd5);
      e.rf[3] = (e.pm == 3'd6 || e.pm == 3'd7);
      e.lo = isel ? ((1 << T_PW) > T_MIN ? (1 << T_PW) : T_MIN) : T_MIN;
      e.hi = e.lo + 6;
      return e;
   endfunction

   // Monitor: scores the decoded outputs when the system reset first rises.
   always @(negedge clk) begin
      if (!cold_rst_n) begin
         relcnt = 0;
         seen   = 0;
      end else begin
         relcnt++;
         if (sys_rst_n === 1'b1 && !seen) begin
            exp_t e;
            seen = 1;
            if (sb.size() == 0) begin
               chk("R3", "unexpected release", 1, 0);
            end else begin
               e = sb.pop_front();
               chk_rng(e.lo == T_MIN ? "R3" : "R4", relcnt, e.lo, e.hi);
               chk("R1/R2", "boot_vec", 32'(boot_vec), 32'(e.vec));
               chk("R6", "pll_bypass", 32'(pll_bypass), 32'(e.byp));
               chk("R6", "mult_factor", 32'(mult_factor), 32'(e.mf));
               chk("R7", "ext_div_factor", 32'(ext_div_factor), 32'(e.df));
               chk("R8", "big_endian", 32'(big_endian), 32'(e.be));
               chk("R9", "pci_mode", 32'(pci_mode), 32'(e.pm));
               chk("R9", "pci_en_init", 32'(pci_en_init), 32'(e.pe));
               chk("R10", "arb_internal", 32'(arb_internal), 32'(e.ai));
               chk("R10", "arb_round_robin", 32'(arb_round_robin), 32'(e.rr));
               chk("R11", "rsv_flags", 32'(rsv_flags), 32'(e.rf));
            end
            got = 1;
         end
      end
   end

   // Driver: one cold reset per call, expected item pushed before release.
   task automatic run_case(input logic [10:0] pins, input bit isel);
      exp_t e;
      @(negedge clk);
      cold_rst_n  = 1'b0;
      boot_pins   = pins;
      int_vec_sel = isel;
      repeat (4) @(negedge clk);
      chk("R3", "sys_rst_n in cold reset", 32'(sys_rst_n), 0);
      e = model(pins, isel);
      sb.push_back(e);
      got = 0;
      cold_rst_n = 1'b1;
      while (!got) @(negedge clk);
      repeat (3) @(negedge clk);
      boot_pins   = ~pins;
      int_vec_sel = ~isel;
      repeat (5) @(negedge clk);
      chk(isel ? "R2" : "R1", "boot_vec after pin change", 32'(boot_vec), 32'(e.vec));
      chk("R5", "sys_rst_n stays high", 32'(sys_rst_n), 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL R3 watchdog: actual=hung expected=release");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R3", "reset state sys_rst_n", 32'(sys_rst_n), 0);
      run_case(11'b000_0_0_00_0000, 1'b0);   // bypass, PCI off
      run_case(11'b001_0_0_00_0001, 1'b0);   // x3, satellite
      run_case(11'b010_0_1_10_0010, 1'b0);   // x4, div 4, big endian, satellite
      run_case(11'b011_0_0_01_0100, 1'b0);   // x5, host external
      run_case(11'b100_0_1_00_0110, 1'b0);   // x6, fixed arbiter
      run_case(11'b101_0_0_01_0111, 1'b0);   // x8, round robin
      run_case(11'b101_0_1_10_1000, 1'b0);   // x10
      run_case(11'b110_1_0_11_0011, 1'b0);   // every field reserved
      run_case(11'b111_0_0_00_1111, 1'b0);   // reserved mult 15, PCI 7
      run_case(11'b000_0_0_00_0000, 1'b1);   // internal vector, PLL wait
      run_case(11'b110_1_1_11_0101, 1'b1);   // internal, garbage pins
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule